// File: doc/BRIEF.md
# FIFO Block-Transfer DMA Ready Generator

This block produces the two active-low request lines that pace a DMA controller moving data in blocks through a UART channel with a 64-entry transmit FIFO and a 64-entry receive FIFO. It does not hold any data. It watches the occupancy count of each FIFO and compares it against a trigger level programmed for each direction. The receive side also takes a receive time-out pulse and a flag that marks an errored character sitting in the receive FIFO.

Each ready line has hysteresis. It turns on at a threshold and then stays on until its FIFO reaches a hard boundary. The transmit request turns on once enough locations are free, and it turns off only when the transmit FIFO is full. The receive request turns on once the fill reaches its trigger, or when a time-out fires. It turns off when the receive FIFO is empty or when the error flag is raised. A DMA engine can therefore move a whole burst per request without the line flickering.

Each direction is a two-state machine. The transmit states are `TX_IDLE` and `TX_READY`, with the transitions `tx_arm` (IDLE to READY) and `tx_full_drop` (READY to IDLE). The receive states are `RX_IDLE` and `RX_READY`. The receive side enters READY by `rx_arm_level` or `rx_arm_timeout` and leaves it by `rx_drop_empty` or `rx_drop_error`. Each output is decoded from its state register, so it changes one clock after the inputs that cause it.

Top module: `dma_ready_gen`

## Requirements
- R1: After reset, `tx_rdy_n` and `rx_rdy_n` are both 1. The value 1 means not ready and 0 means ready.
- R2: When `tx_rdy_n` is 1, the FIFO is not full, and the free count (64 − `tx_fill`) is at least the effective transmit trigger, `tx_rdy_n` is 0 after the next clock.
- R3: Once `tx_rdy_n` is 0, it stays 0 while `tx_fill` is below 64, even when the free count falls below the trigger.
- R4: `tx_rdy_n` is 1 after the clock at which `tx_fill` equals 64.
- R5: When `rx_rdy_n` is 1, `rx_fill` is at least the effective receive trigger, `rx_fill` is nonzero and `rx_err` is 0, `rx_rdy_n` is 0 after the next clock.
- R6: A clock with `rx_timeout` at 1, nonzero `rx_fill` and `rx_err` at 0 makes `rx_rdy_n` 0 after that clock, even when the fill is below the trigger.
- R7: Once `rx_rdy_n` is 0, it stays 0 while `rx_fill` is nonzero and `rx_err` is 0, even when the fill drops below the trigger.
- R8: `rx_rdy_n` is 1 after a clock at which `rx_fill` is 0.
- R9: `rx_rdy_n` is 1 after a clock at which `rx_err` is 1.
- R10: A trigger input of 0 acts as 1, and a trigger input above 64 acts as 64, in both directions.
- R11: When an assert condition and a deassert condition hold in the same clock, the deassert wins. For example, a trigger or time-out together with `rx_err` or an empty FIFO leaves `rx_rdy_n` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_fill | input | 7 | Transmit FIFO occupancy, 0 to 64 |
| tx_trig | input | 7 | Transmit trigger: free locations needed to request |
| rx_fill | input | 7 | Receive FIFO occupancy, 0 to 64 |
| rx_trig | input | 7 | Receive trigger: filled locations needed to request |
| rx_timeout | input | 1 | One-cycle receive time-out event |
| rx_err | input | 1 | Errored character present in the receive FIFO |
| tx_rdy_n | output | 1 | Transmit DMA request, active low |
| rx_rdy_n | output | 1 | Receive DMA request, active low |

## Verification
The only internal state is one bit per direction. A wrong value of that bit shows on the matching ready pin at the very next clock. A stuck or mis-set state bit is therefore visible in the first cycle whose inputs sit between the arm threshold and the drop boundary, where only the remembered state decides the output. The bench sweeps every fill count up and down for every trigger from 0 to 70, so it crosses those hysteresis bands at every level. On the receive side the sweep mixes in time-out and error pulses at varying fills, which also exercises the same-cycle conflicts.

// File: rtl/dma_ready_pkg.sv
package dma_ready_pkg;

    typedef enum logic {
        TX_IDLE  = 1'b0,
        TX_READY = 1'b1
    } tx_state_e;

    typedef enum logic {
        RX_IDLE  = 1'b0,
        RX_READY = 1'b1
    } rx_state_e;

    // Index of each direction in the trigger normalisation array
    localparam int DIR_TX = 0;
    localparam int DIR_RX = 1;
    localparam int N_DIR  = 2;

endpackage

// File: rtl/dma_trig_norm.sv
module dma_trig_norm #(
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0] trig_raw,
    output logic [CNT_W-1:0] trig_eff
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

    always_comb begin
        if (trig_raw == '0) begin
            trig_eff = ONE_C;
        end else if (trig_raw > DEPTH_C) begin
            trig_eff = DEPTH_C;
        end else begin
            trig_eff = trig_raw;
        end
    end

    always_comb begin
        AST_TRIG_IN_RANGE: assert (trig_eff >= ONE_C && trig_eff <= DEPTH_C); // R10
    end

endmodule

// File: rtl/dma_tx_ready_fsm.sv
module dma_tx_ready_fsm
    import dma_ready_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] fill,
    input  logic [CNT_W-1:0] trig_eff,
    output logic             rdy_n
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    tx_state_e   state_q;
    tx_state_e   state_d;
    logic        is_full;
    logic        can_arm;
    logic [CNT_W-1:0] free_cnt;

    assign is_full  = (fill >= DEPTH_C);
    assign free_cnt = is_full ? '0 : (DEPTH_C - fill);
    assign can_arm  = (free_cnt >= trig_eff);

    // next state: the full boundary outranks the arm threshold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: begin
                if (!is_full && can_arm) begin
                    state_d = TX_READY;        // tx_arm
                end
            end
            TX_READY: begin
                if (is_full) begin
                    state_d = TX_IDLE;         // tx_full_drop
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        rdy_n = (state_q != TX_READY);
    end

    AST_TX_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> rdy_n); // R1
    AST_TX_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_n && fill < DEPTH_C && (DEPTH_C - fill) >= trig_eff) |=> !rdy_n); // R2
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_n && fill < DEPTH_C) |=> !rdy_n); // R3
    AST_TX_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == DEPTH_C) |=> rdy_n); // R4

endmodule

// File: rtl/dma_rx_ready_fsm.sv
module dma_rx_ready_fsm
    import dma_ready_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] fill,
    input  logic [CNT_W-1:0] trig_eff,
    input  logic             timeout,
    input  logic             err,
    output logic             rdy_n
);
    rx_state_e state_q;
    rx_state_e state_d;
    logic      is_empty;
    logic      drop;
    logic      arm_level;
    logic      arm_tmo;

    assign is_empty  = (fill == '0);
    assign drop      = is_empty || err;
    assign arm_level = (fill >= trig_eff);
    assign arm_tmo   = timeout;

    // next state: empty and error outrank level and time-out arming
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: begin
                if (!drop && arm_level) begin
                    state_d = RX_READY;        // rx_arm_level
                end else if (!drop && arm_tmo) begin
                    state_d = RX_READY;        // rx_arm_timeout
                end
            end
            RX_READY: begin
                if (err) begin
                    state_d = RX_IDLE;         // rx_drop_error
                end else if (is_empty) begin
                    state_d = RX_IDLE;         // rx_drop_empty
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        rdy_n = (state_q != RX_READY);
    end

    AST_RX_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> rdy_n); // R1
    AST_RX_ARM_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (fill != '0 && !err && fill >= trig_eff) |=> !rdy_n); // R5
    AST_RX_ARM_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout && fill != '0 && !err) |=> !rdy_n); // R6
    AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_n && fill != '0 && !err) |=> !rdy_n); // R7
    AST_RX_DROP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == '0) |=> rdy_n); // R8
    AST_RX_DROP_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> rdy_n); // R9

endmodule

// File: rtl/dma_ready_gen.sv
module dma_ready_gen
    import dma_ready_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tx_fill,
    input  logic [CNT_W-1:0] tx_trig,
    input  logic [CNT_W-1:0] rx_fill,
    input  logic [CNT_W-1:0] rx_trig,
    input  logic             rx_timeout,
    input  logic             rx_err,
    output logic             tx_rdy_n,
    output logic             rx_rdy_n
);
    logic [N_DIR-1:0][CNT_W-1:0] trig_raw;
    logic [N_DIR-1:0][CNT_W-1:0] trig_eff;

    assign trig_raw[DIR_TX] = tx_trig;
    assign trig_raw[DIR_RX] = rx_trig;

    for (genvar g = 0; g < N_DIR; g++) begin : g_norm
        dma_trig_norm #(
            .DEPTH (DEPTH),
            .CNT_W (CNT_W)
        ) u_norm (
            .trig_raw (trig_raw[g]),
            .trig_eff (trig_eff[g])
        );
    end

    dma_tx_ready_fsm #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .fill     (tx_fill),
        .trig_eff (trig_eff[DIR_TX]),
        .rdy_n    (tx_rdy_n)
    );

    dma_rx_ready_fsm #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .fill     (rx_fill),
        .trig_eff (trig_eff[DIR_RX]),
        .timeout  (rx_timeout),
        .err      (rx_err),
        .rdy_n    (rx_rdy_n)
    );

    AST_RX_CONFLICT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_err && (rx_timeout || rx_fill != '0)) |=> rx_rdy_n); // R11

endmodule

// File: tb/dma_ready_gen_bench.sv
module dma_ready_gen_bench;
    localparam int DEPTH = 64;
    localparam int CW    = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] tx_fill = '0;
    logic [CW-1:0] tx_trig = '0;
    logic [CW-1:0] rx_fill = '0;
    logic [CW-1:0] rx_trig = '0;
    logic          rx_timeout = 1'b0;
    logic          rx_err = 1'b0;
    logic          tx_rdy_n;
    logic          rx_rdy_n;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  exp_tx  = 1'b0;
    bit  exp_rx  = 1'b0;

    always #10 clk = ~clk;

    dma_ready_gen #(.DEPTH(DEPTH)) u_dma_ready_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_fill    (tx_fill),
        .tx_trig    (tx_trig),
        .rx_fill    (rx_fill),
        .rx_trig    (rx_trig),
        .rx_timeout (rx_timeout),
        .rx_err     (rx_err),
        .tx_rdy_n   (tx_rdy_n),
        .rx_rdy_n   (rx_rdy_n)
    );

    function automatic int eff(input int t);
        if (t == 0) return 1;
        if (t > DEPTH) return DEPTH;
        return t;
    endfunction

    task automatic check(input logic act, input logic exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Called at a falling edge; drives inputs, updates the model, checks after the rising edge.
    task automatic step(input int txf, input int txt, input int rxf, input int rxt,
                        input bit tmo, input bit er);
        string tx_tag;
        string rx_tag;
        bit    tx_arm;
        bit    rx_arm;
        bit    rx_drop;
        tx_fill = CW'(txf);
        tx_trig = CW'(txt);
        rx_fill = CW'(rxf);
        rx_trig = CW'(rxt);
        rx_timeout = tmo;
        rx_err  = er;

        tx_arm = ((DEPTH - txf) >= eff(txt));
        if (txf == DEPTH)               tx_tag = "R4";
        else if (exp_tx)                tx_tag = "R3";
        else if (txt == 0 || txt > DEPTH) tx_tag = "R10";
        else                            tx_tag = "R2";
        if (txf == DEPTH) exp_tx = 1'b0;
        else if (tx_arm)  exp_tx = 1'b1;

        rx_arm  = (rxf >= eff(rxt)) || tmo;
        rx_drop = (rxf == 0) || er;
        if (rx_drop && rx_arm && !exp_rx) rx_tag = "R11";
        else if (er)                      rx_tag = "R9";
        else if (rxf == 0)                rx_tag = "R8";
        else if (exp_rx)                  rx_tag = "R7";
        else if (rxf >= eff(rxt))         rx_tag = (rxt == 0 || rxt > DEPTH) ? "R10" : "R5";
        else if (tmo)                     rx_tag = "R6";
        else                              rx_tag = "R5";
        if (rx_drop)     exp_rx = 1'b0;
        else if (rx_arm) exp_rx = 1'b1;

        @(posedge clk);
        #5;
        check(tx_rdy_n, !exp_tx, tx_tag);
        check(rx_rdy_n, !exp_rx, rx_tag);
        @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        check(tx_rdy_n, 1'b1, "R1");
        check(rx_rdy_n, 1'b1, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Transmit sweep: fill rises to full then drains, for every trigger 0..70
        for (int t = 0; t <= 70; t++) begin
            for (int f = 0; f <= DEPTH; f++) step(f, t, 0, 1, 1'b0, 1'b0);
            for (int f = DEPTH; f >= 0; f--) step(f, t, 0, 1, 1'b0, 1'b0);
        end

        // Receive sweep with interleaved time-out and error events
        for (int t = 0; t <= 70; t++) begin
            for (int f = 0; f <= DEPTH; f++)
                step(DEPTH, 1, f, t, ((f * 7 + t) % 11) == 0, ((f * 5 + t * 3) % 23) == 0);
            for (int f = DEPTH; f >= 0; f--)
                step(DEPTH, 1, f, t, ((f * 3 + t) % 13) == 0, ((f + t * 7) % 29) == 0);
        end

        // Directed corners
        step(DEPTH, 1, 5, 20, 1'b1, 1'b0);   // R6 time-out below trigger
        step(DEPTH, 1, 2, 20, 1'b0, 1'b0);   // R7 hold below trigger
        step(DEPTH, 1, 0, 20, 1'b0, 1'b0);   // R8 empty drop
        step(DEPTH, 1, 30, 20, 1'b1, 1'b1);  // R11 both arms vs error
        step(DEPTH, 1, 0, 0, 1'b1, 1'b0);    // R11 time-out vs empty
        step(DEPTH, 1, 1, 0, 1'b0, 1'b0);    // R10 zero trigger acts as one
        step(DEPTH, 127, 64, 127, 1'b0, 1'b0); // R10 oversize trigger acts as 64
        step(0, 127, 64, 1, 1'b0, 1'b0);     // R10 tx with oversize trigger

        // Reset mid-run returns both outputs to idle
        rst_n = 1'b0;
        #5;
        check(tx_rdy_n, 1'b1, "R1");
        check(rx_rdy_n, 1'b1, "R1");
        exp_tx = 1'b0;
        exp_rx = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        step(10, 30, 40, 30, 1'b0, 1'b0);    // R2 and R5 after re-reset

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule